// File: doc/BRIEF.md
# Serial ADC Device Model with Wake-Up and Protocol Checks

This block stands in for a 12-bit serial-output ADC on the device side of a link. A readout controller under test drives chip select, the serial clock and a shutdown line. The model answers on a data pin with a separate enable that stands for the high-impedance state. The value to be "converted" arrives as a parallel word. The model captures it at the moment chip select goes low. It then returns the word one bit per serial clock rising edge: a short run of zeros first, then the data with the most significant bit first, and then zeros for any extra edges.

All three control inputs are treated as asynchronous. They pass through a synchronizer in the model's own clock domain and are then edge-detected, so the serial clock must run well below the model clock. The model also checks the controller's behaviour. It keeps a wake-up interval after shutdown is released, and it raises a sticky error flag when a conversion starts too early or ends before the whole word has been clocked out. The parallel sample is a plain level input with no handshake. It is sampled only at the start of a conversion, so it imposes no back-pressure and carries no valid qualifier.

Top module: `serial_adc_model`

## Requirements
- R1: After reset, and whenever chip select is high, `dout_en` is 0 and `dout` is 0. `proto_err` resets to 0.
- R2: A chip-select falling edge raises `dout_en` with `dout` = 0 on the third model clock edge after the input change. The input synchronizer is two stages deep and the edge detector adds one more register.
- R3: `sample` is captured at the chip-select falling edge. Changes to it during the conversion do not affect the bits shifted out.
- R4: The first and second serial clock rising edges of a conversion leave `dout` at 0.
- R5: Rising edges 3 through 14 present sample bits 11 down to 0, one bit per edge, MSB first.
- R6: Rising edges after the 14th, up to chip select rising, hold `dout` at 0.
- R7: Chip select rising returns `dout_en` to 0. The next falling edge restarts the edge count and reloads a fresh sample.
- R8: A chip-select falling edge while `shdn` is high sets `proto_err`.
- R9: After `shdn` is released, a chip-select falling edge sets `proto_err` until WAKE_CYCLES model clocks have elapsed. A start after that interval does not set it.
- R10: Chip select rising after fewer than 15 serial clock rising edges sets `proto_err`. Exactly 15 edges or more do not set it.
- R11: `proto_err` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Model sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| sclk | input | 1 | Serial clock from the controller, asynchronous |
| shdn | input | 1 | Shutdown request, active high, asynchronous |
| sample | input | DATA_W | Parallel value returned by the next conversion |
| dout | output | 1 | Serial data bit |
| dout_en | output | 1 | High when the data pin is driven; low means high impedance |
| proto_err | output | 1 | Sticky flag for an early start or a short frame |

## Verification
The bench sweeps walking-one values and an arithmetic spread of sample words. It checks every serial edge against the bit computed from the word. A model that is off by one edge in the lead-in would show the MSB on the second edge or shift the LSB into the tail. A model that read `sample` late would return the inverted word that the bench drives straight after the start. The frame length is tested at exactly 15 edges and at 14 edges, which catches a comparison that is off by one in either direction. The wake-up window is probed both well inside it and beyond it, so a model that ignored the counter, or that never let it expire, would flag the wrong case.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

  // Per-cycle events seen after synchronization and edge detection
  typedef struct packed {
    logic cs_fall;
    logic cs_rise;
    logic sclk_rise;
  } sadc_evt_t;

  // Bit positions inside the synchronized control vector
  localparam int unsigned CTL_CS   = 0;
  localparam int unsigned CTL_SCLK = 1;
  localparam int unsigned CTL_SHDN = 2;
  localparam int unsigned CTL_W    = 3;

  // Idle levels: chip select high, clock low, awake
  localparam logic [CTL_W-1:0] CTL_IDLE = 3'b001;

endpackage

// File: rtl/sadc_sync.sv
module sadc_sync #(
  parameter int unsigned W        = 3,
  parameter int unsigned STAGES   = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] level,
  output logic [W-1:0] prev
);

  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= {STAGES{RST_VAL}};
      prev <= RST_VAL;
    end else begin
      pipe[0] <= async_in;
      for (int s = 1; s < STAGES; s++) begin
        pipe[s] <= pipe[s-1];
      end
      prev <= pipe[STAGES-1];
    end
  end

  assign level = pipe[STAGES-1];

endmodule

// File: rtl/sadc_wake.sv
module sadc_wake #(
  parameter int unsigned WAKE_CYCLES = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shdn_lvl,
  input  logic shdn_prev,
  output logic awake
);

  localparam int unsigned WCW = (WAKE_CYCLES < 1) ? 1 : $clog2(WAKE_CYCLES + 1);
  localparam logic [WCW-1:0] WLOAD = WCW'(WAKE_CYCLES);

  logic [WCW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (shdn_lvl) begin
      remain <= WLOAD;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign awake = !shdn_lvl && (remain == '0);

  generate
    if (WAKE_CYCLES > 0) begin : g_wake_chk
      AST_WAKE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (shdn_prev && !shdn_lvl) |-> !awake); // R9
    end
  endgenerate

endmodule

// File: rtl/sadc_shifter.sv
module sadc_shifter #(
  parameter int unsigned DATA_W     = 12,
  parameter int unsigned LEAD_ZEROS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  input  logic              step,
  input  logic [DATA_W-1:0] sample,
  output logic              dout,
  output logic              dout_en,
  output logic              busy,
  output logic              frame_done
);

  localparam int unsigned FRAME = LEAD_ZEROS + DATA_W;
  localparam int unsigned CW    = $clog2(FRAME + 1);
  localparam logic [CW-1:0] FIRST_DATA = CW'(LEAD_ZEROS - 1);
  localparam logic [CW-1:0] END_DATA   = CW'(FRAME - 1);
  localparam logic [CW-1:0] FULL       = CW'(FRAME);

  logic [CW-1:0]     edges;
  logic [DATA_W-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      dout_en <= 1'b0;
      dout    <= 1'b0;
      edges   <= '0;
      shreg   <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      dout_en <= 1'b1;
      dout    <= 1'b0;
      edges   <= '0;
      shreg   <= sample;
    end else if (stop) begin
      busy    <= 1'b0;
      dout_en <= 1'b0;
      dout    <= 1'b0;
    end else if (step && busy) begin
      if (edges != FULL) edges <= edges + 1'b1;
      if (edges >= FIRST_DATA && edges < END_DATA) begin
        dout  <= shreg[DATA_W-1];
        shreg <= {shreg[DATA_W-2:0], 1'b0};
      end else begin
        dout <= 1'b0;
      end
    end
  end

  assign frame_done = (edges == FULL);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> !dout); // R1
  AST_START_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (dout_en && !dout && edges == '0)); // R2
  AST_LEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && edges <= FIRST_DATA) |-> !dout); // R4
  AST_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (step && busy && !start && !stop && edges == FIRST_DATA) |=> (dout == $past(shreg[DATA_W-1]))); // R5
  AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && edges == FULL) |-> !dout); // R6

endmodule

// File: rtl/serial_adc_model.sv
module serial_adc_model #(
  parameter int unsigned DATA_W      = 12,
  parameter int unsigned LEAD_ZEROS  = 3,
  parameter int unsigned WAKE_CYCLES = 4000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              shdn,
  input  logic [DATA_W-1:0] sample,
  output logic              dout,
  output logic              dout_en,
  output logic              proto_err
);
  import sadc_pkg::*;

  logic [CTL_W-1:0] ctl_raw, ctl_lvl, ctl_prev;
  sadc_evt_t        evt;
  logic             awake, busy, frame_done, err_set;

  assign ctl_raw[CTL_CS]   = cs_n;
  assign ctl_raw[CTL_SCLK] = sclk;
  assign ctl_raw[CTL_SHDN] = shdn;

  sadc_sync #(
    .W      (CTL_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(CTL_IDLE)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(ctl_raw),
    .level   (ctl_lvl),
    .prev    (ctl_prev)
  );

  assign evt.cs_fall   = ctl_prev[CTL_CS] && !ctl_lvl[CTL_CS];
  assign evt.cs_rise   = !ctl_prev[CTL_CS] && ctl_lvl[CTL_CS];
  assign evt.sclk_rise = !ctl_prev[CTL_SCLK] && ctl_lvl[CTL_SCLK];

  sadc_wake #(
    .WAKE_CYCLES(WAKE_CYCLES)
  ) u_wake (
    .clk      (clk),
    .rst_n    (rst_n),
    .shdn_lvl (ctl_lvl[CTL_SHDN]),
    .shdn_prev(ctl_prev[CTL_SHDN]),
    .awake    (awake)
  );

  sadc_shifter #(
    .DATA_W    (DATA_W),
    .LEAD_ZEROS(LEAD_ZEROS)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (evt.cs_fall),
    .stop      (evt.cs_rise),
    .step      (evt.sclk_rise),
    .sample    (sample),
    .dout      (dout),
    .dout_en   (dout_en),
    .busy      (busy),
    .frame_done(frame_done)
  );

  assign err_set = (evt.cs_fall && !awake) || (evt.cs_rise && busy && !frame_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) proto_err <= 1'b0;
    else if (err_set) proto_err <= 1'b1;
  end

  AST_SHDN_START: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.cs_fall && ctl_lvl[CTL_SHDN]) |=> proto_err); // R8
  AST_SHORT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.cs_rise && busy && !frame_done) |=> proto_err); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err); // R11
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.cs_rise && !evt.cs_fall) |=> !dout_en); // R7

endmodule

// File: tb/serial_adc_model_tb.sv
module serial_adc_model_tb;

  localparam int unsigned DW   = 12;
  localparam int unsigned WAKE = 40;
  localparam int unsigned SET  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic shdn = 1'b0;
  logic [DW-1:0] sample = '0;
  logic dout, dout_en, proto_err;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  serial_adc_model #(
    .DATA_W(DW), .LEAD_ZEROS(3), .WAKE_CYCLES(WAKE), .SYNC_STAGES(2)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .shdn(shdn),
    .sample(sample), .dout(dout), .dout_en(dout_en), .proto_err(proto_err)
  );

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; shdn = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(2);
  endtask

  // One conversion with nedges serial rising edges; checks each bit
  task automatic do_conv(input logic [DW-1:0] val, input int nedges, input bit exp_err);
    logic [DW-1:0] v;
    v = val;
    sample = v;
    cs_n = 1'b0;
    tick(SET);
    check(dout_en === 1'b1 && dout === 1'b0, "R2 start drive", {dout_en, dout}, 2);
    sample = ~v; // R3: later changes must not matter
    for (int e = 1; e <= nedges; e++) begin
      logic expb;
      sclk = 1'b1;
      tick(SET);
      expb = (e >= 3 && e <= 14) ? v[14-e] : 1'b0;
      if (e <= 2)       check(dout === expb, "R4 lead zero", dout, expb);
      else if (e <= 14) check(dout === expb, "R5/R3 data bit", dout, expb);
      else              check(dout === expb, "R6 tail zero", dout, expb);
      sclk = 1'b0;
      tick(SET);
    end
    cs_n = 1'b1;
    tick(SET);
    check(dout_en === 1'b0 && dout === 1'b0, "R7 release", {dout_en, dout}, 0);
    check(proto_err === exp_err, "R10 frame length flag", proto_err, exp_err);
  endtask

  initial begin
    do_reset();
    check(dout_en === 1'b0 && dout === 1'b0, "R1 reset idle", {dout_en, dout}, 0);
    check(proto_err === 1'b0, "R1 reset flag", proto_err, 0);

    // R2 exact latency: enable appears on the third clock edge
    sample = 12'hA5C;
    cs_n = 1'b0;
    tick(2);
    check(dout_en === 1'b0, "R2 not before third edge", dout_en, 0);
    tick(1);
    check(dout_en === 1'b1 && dout === 1'b0, "R2 on third edge", {dout_en, dout}, 2);
    cs_n = 1'b1;
    tick(SET);
    do_reset();

    // Walking ones and an arithmetic spread, with extra tail edges
    for (int b = 0; b < DW; b++) do_conv(12'(1 << b), 17, 1'b0);
    for (int k = 0; k < 20; k++) do_conv(12'((k * 683 + 7) % 4096), 16, 1'b0);
    do_conv(12'hFFF, 15, 1'b0);
    do_conv(12'h000, 15, 1'b0);

    // R10 boundary and R11 stickiness
    do_conv(12'h3C7, 14, 1'b1);
    do_conv(12'h5A5, 16, 1'b1); // R11 still set, R7 restart reloads value
    do_reset();
    check(proto_err === 1'b0, "R11 cleared by reset", proto_err, 0);

    // R8: start during shutdown
    shdn = 1'b1;
    tick(SET);
    do_conv(12'h123, 15, 1'b1);
    shdn = 1'b0;
    do_reset();

    // R9: start inside the wake window
    shdn = 1'b1;
    tick(SET);
    shdn = 1'b0;
    tick(5);
    do_conv(12'h456, 15, 1'b1);
    do_reset();

    // R9: start after the wake window
    shdn = 1'b1;
    tick(SET);
    shdn = 1'b0;
    tick(WAKE + 20);
    do_conv(12'h789, 15, 1'b0);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 150000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule